// File: doc/BRIEF.md
# Programmable Channel Divider with Three-State Phase Detector and Lock Flag

This block is the digital core of one synthesizer loop. A 14-bit programmable counter divides a stream of VCO ticks by a divisor N. Each terminal count produces a divided edge, and a phase-frequency detector compares it with a reference tick. The detector drives two enables for a three-state charge-pump pin. The drive-low enable is pulsed when the divided signal is fast or leading. The drive-high enable is pulsed when it is slow or lagging. When the two edges coincide, neither enable is set and the pin floats. A lock detector watches the width of the detector pulses and raises an unlock flag whenever the loop is out of lock.

All inputs are synchronous to the system clock. The VCO tick and the reference tick are one-cycle strobes, one per edge of the respective signal. Software-visible control sits outside the block. A divisor word with a load strobe retunes the channel. A single power-down input idles the whole loop; it is driven by the receive or transmit battery-save bit, depending on which loop is built. The reset divisor is a parameter: 7215 for a receive loop and 9966 for a transmit loop.

Top module: `chdiv_channel_path`

## Requirements
- R1: The division ratio equals the loaded 14-bit word for words 16 to 16383. Any word from 0 to 15 is treated as 16. With one VCO tick per clock, successive divided edges are N clock cycles apart.
- R2: After power-down is released, with no reference tick, `drv_lo_en` first rises one clock edge after the edge that samples the N-th VCO tick. That is, it is first observed high after N+1 edges.
- R3: A word loaded part-way through a division cycle does not shorten or lengthen that cycle. It sets the length of the cycle that starts at the next terminal count.
- R4: A divided edge that arrives before the reference sets `drv_lo_en`. A reference tick that arrives before the divided edge sets `drv_hi_en`. The active enable stays high until the edge that samples the other event, and it is cleared by that edge.
- R5: When the divided edge and the reference tick are sampled on the same clock edge, neither enable is set, so the pin floats. `drv_hi_en` and `drv_lo_en` are never high together.
- R6: `unlock` goes low (locked) on the fourth consecutive reference tick whose reference period contained no detector pulse 2 or more clock cycles wide. It can only go low on a reference tick.
- R7: When any detector pulse reaches its second cycle, `unlock` reads 1 after the next clock edge.
- R8: While `pwr_down` is 1, the counter is held at zero, both enables are 0, and `unlock` is 1. Divisor loads are still accepted, and the counter restarts from zero on release.
- R9: After reset, both enables are 0, `unlock` is 1, and the divisor is the parameter default: 7215 for a receive loop, 9966 for a transmit loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_word | input | 14 | New channel divisor |
| div_load | input | 1 | Strobe that captures div_word |
| vco_tick | input | 1 | One-cycle strobe per VCO edge |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| pwr_down | input | 1 | Battery-save power-down of this loop |
| drv_hi_en | output | 1 | Pump-up enable (pin driven high) |
| drv_lo_en | output | 1 | Pump-down enable (pin driven low) |
| unlock | output | 1 | 1 while out of lock, 0 while locked |

## Verification
The bench builds the block with its default parameters: a 14-bit divisor, the 7215 receive default, a 2-cycle pulse limit and a 4-tick lock count. It drives one VCO tick per clock, so every divisor shows up directly as a count of clock cycles. This lets it sweep every clamped word, each divisor from 16 to 48, the 16383 maximum and the full-length default period. It also answers each divided edge with a reference tick after a chosen delay, which places the detector pulse widths exactly on either side of the 2-cycle limit. That covers lock gain, lock loss, relock and a mid-cycle divisor change.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;

    localparam int DIV_W          = 14;
    localparam int DIV_MIN        = 16;
    localparam int RX_DEFAULT_DIV = 7215;
    localparam int TX_DEFAULT_DIV = 9966;

    // Words below the legal floor divide by the floor.
    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] w);
        return (w < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : w;
    endfunction

endpackage

// File: rtl/chdiv_counter.sv
module chdiv_counter
    import chdiv_pkg::*;
#(
    parameter int RESET_DIV = RX_DEFAULT_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd,
    input  logic             vco_tick,
    input  logic             load,
    input  logic [DIV_W-1:0] load_word,
    output logic             div_edge
);

    localparam int               RESET_CLAMPED = (RESET_DIV < DIV_MIN) ? DIV_MIN : RESET_DIV;
    localparam logic [DIV_W-1:0] RESET_WORD    = DIV_W'(RESET_CLAMPED);

    typedef struct packed {
        logic [DIV_W-1:0] count;
        logic [DIV_W-1:0] active;
        logic [DIV_W-1:0] pending;
        logic             pulse;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [DIV_W-1:0] last_cnt;
    logic [DIV_W-1:0] word_c;
    logic             terminal;

    always_comb begin
        last_cnt = st_q.active - 1'b1;
        word_c   = clamp_div(load_word);
        terminal = vco_tick && (st_q.count == last_cnt);
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (load) begin
            st_d.pending = word_c;
        end
        if (pd) begin
            st_d.count  = '0;
            st_d.active = load ? word_c : st_q.pending;
        end else if (vco_tick) begin
            if (terminal) begin
                st_d.count  = '0;
                st_d.pulse  = 1'b1;
                st_d.active = load ? word_c : st_q.pending;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{count: '0, active: RESET_WORD, pending: RESET_WORD, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_edge = st_q.pulse;

    // R1: the divisor in use never falls below the floor
    p_active_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active >= DIV_W'(DIV_MIN));

    // R1: the count stays inside the current ratio
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count < st_q.active);

    // R3: the ratio changes only at a terminal count or while idle
    p_keep_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && !terminal) |=> (st_q.active == $past(st_q.active)));

endmodule

// File: rtl/chdiv_pfd.sv
module chdiv_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic ref_edge,
    input  logic div_edge,
    output logic pump_up,
    output logic pump_dn
);

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_st_t;

    pfd_st_t st_d, st_q;
    logic    up_set, dn_set;

    always_comb begin
        up_set = st_q.up | ref_edge;
        dn_set = st_q.dn | div_edge;
        st_d   = st_q;
        if (pd || (up_set && dn_set)) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end else begin
            st_d.up = up_set;
            st_d.dn = dn_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{up: 1'b0, dn: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pump_up = st_q.up;
    assign pump_dn = st_q.dn;

    // R5: the pin is never driven both ways
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.up && st_q.dn));

    // R4: a lone divided edge starts a pump-down pulse
    p_dn_on_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && div_edge && !ref_edge && !st_q.up) |=> st_q.dn);

    // R4: a lone reference edge starts a pump-up pulse
    p_up_on_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && ref_edge && !div_edge && !st_q.dn) |=> st_q.up);

endmodule

// File: rtl/chdiv_lock.sv
module chdiv_lock #(
    parameter int PULSE_LIMIT = 2,
    parameter int LOCK_REFS   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic ref_edge,
    input  logic pump_up,
    input  logic pump_dn,
    output logic unlock
);

    localparam int WID_W  = $clog2(PULSE_LIMIT + 1);
    localparam int GOOD_W = $clog2(LOCK_REFS + 1);

    typedef struct packed {
        logic [WID_W-1:0]  wid;
        logic [GOOD_W-1:0] good;
        logic              seen;
        logic              locked;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     pulsing;
    logic     wide_now;

    always_comb begin
        pulsing  = pump_up | pump_dn;
        wide_now = pulsing && (int'(st_q.wid) + 1 >= PULSE_LIMIT);
        st_d     = st_q;
        if (pulsing) begin
            st_d.wid = (int'(st_q.wid) >= PULSE_LIMIT) ? st_q.wid : st_q.wid + 1'b1;
        end else begin
            st_d.wid = '0;
        end
        if (ref_edge) begin
            // a wide pulse ending on this tick belongs to the period just closed
            st_d.good = (st_q.seen || wide_now) ? '0 :
                        ((int'(st_q.good) >= LOCK_REFS) ? st_q.good : st_q.good + 1'b1);
            st_d.seen = 1'b0;
        end else if (wide_now) begin
            st_d.good = '0;
            st_d.seen = 1'b1;
        end
        st_d.locked = (int'(st_d.good) >= LOCK_REFS);
        if (pd) begin
            st_d = '{wid: '0, good: '0, seen: 1'b0, locked: 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wid: '0, good: '0, seen: 1'b0, locked: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign unlock = ~st_q.locked;

    // R7: an over-long pulse drops lock on the next edge
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wide_now |=> !st_q.locked);

    // R6: lock is gained only on a reference tick
    p_gain_on_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.locked && !ref_edge) |=> !st_q.locked);

endmodule

// File: rtl/chdiv_channel_path.sv
module chdiv_channel_path
    import chdiv_pkg::*;
#(
    parameter int RESET_DIV   = RX_DEFAULT_DIV,
    parameter int PULSE_LIMIT = 2,
    parameter int LOCK_REFS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_word,
    input  logic             div_load,
    input  logic             vco_tick,
    input  logic             ref_tick,
    input  logic             pwr_down,
    output logic             drv_hi_en,
    output logic             drv_lo_en,
    output logic             unlock
);

    logic div_edge;
    logic pump_up, pump_dn;

    chdiv_counter #(
        .RESET_DIV (RESET_DIV)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd        (pwr_down),
        .vco_tick  (vco_tick),
        .load      (div_load),
        .load_word (div_word),
        .div_edge  (div_edge)
    );

    chdiv_pfd u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd       (pwr_down),
        .ref_edge (ref_tick),
        .div_edge (div_edge),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn)
    );

    chdiv_lock #(
        .PULSE_LIMIT (PULSE_LIMIT),
        .LOCK_REFS   (LOCK_REFS)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd       (pwr_down),
        .ref_edge (ref_tick),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .unlock   (unlock)
    );

    assign drv_hi_en = pump_up;
    assign drv_lo_en = pump_dn;

    // R8: power-down floats the pin and reports unlocked
    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!drv_hi_en && !drv_lo_en && unlock));

endmodule

// File: tb/chdiv_channel_path_tb_top.sv
module chdiv_channel_path_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] div_word;
    logic        div_load, vco_tick, ref_tick, pwr_down;
    logic        drv_hi_en, drv_lo_en, unlock;
    int          checks = 0;
    int          failures = 0;

    always #5 clk = ~clk;

    chdiv_channel_path dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_word  (div_word),
        .div_load  (div_load),
        .vco_tick  (vco_tick),
        .ref_tick  (ref_tick),
        .pwr_down  (pwr_down),
        .drv_hi_en (drv_hi_en),
        .drv_lo_en (drv_lo_en),
        .unlock    (unlock)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R8: idle the loop, load a word while idle, then release with ticks running
    task automatic restart(input int word);
        vco_tick = 1'b0; ref_tick = 1'b0;
        pwr_down = 1'b1; div_load = 1'b1; div_word = 14'(word);
        step();
        div_load = 1'b0;
        step();
        chk("R8 pd drv_hi_en", int'(drv_hi_en), 0);
        chk("R8 pd drv_lo_en", int'(drv_lo_en), 0);
        chk("R8 pd unlock", int'(unlock), 1);
        pwr_down = 1'b0; vco_tick = 1'b1;
    endtask

    task automatic wait_lo(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!drv_lo_en && n < 20000);
    endtask

    // wait for a divided edge, answer it with a reference tick after 'delay' cycles
    task automatic follow(input int delay, output int n);
        wait_lo(n);
        for (int d = 0; d < delay; d++) step();
        ref_tick = 1'b1;
        step();
        ref_tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; div_word = '0; div_load = 1'b0;
        vco_tick = 1'b0; ref_tick = 1'b0; pwr_down = 1'b0;
        repeat (3) step();
        chk("R9 reset drv_hi_en", int'(drv_hi_en), 0);
        chk("R9 reset drv_lo_en", int'(drv_lo_en), 0);
        chk("R9 reset unlock", int'(unlock), 1);
        rst_n = 1'b1;
        vco_tick = 1'b1;
        wait_lo(n);
        chk("R9 default receive divisor", n, 7215 + 1);

        // R1 clamp and R2 first-edge latency over a sweep of words
        for (int w = 0; w <= 48; w++) begin
            restart(w);
            wait_lo(n);
            chk(w < 16 ? "R1 clamp to 16" : "R2 first edge", n, ((w < 16) ? 16 : w) + 1);
        end
        restart(16383);
        wait_lo(n);
        chk("R1 max divisor", n, 16384);

        // R4 reference first: pump-up until the divided edge
        restart(20);
        ref_tick = 1'b1;
        step();
        ref_tick = 1'b0;
        chk("R4 up on early ref", int'(drv_hi_en), 1);
        chk("R4 no dn on early ref", int'(drv_lo_en), 0);
        repeat (19) step();
        chk("R4 up held to edge 20", int'(drv_hi_en), 1);
        step();
        chk("R4 up cleared by div edge", int'(drv_hi_en), 0);
        chk("R5 float after clear", int'(drv_lo_en), 0);
        chk("R7 wide up pulse unlocked", int'(unlock), 1);

        // R5 coincident edges
        restart(16);
        repeat (16) step();
        chk("R5 before coincidence lo", int'(drv_lo_en), 0);
        ref_tick = 1'b1;
        step();
        ref_tick = 1'b0;
        chk("R5 coincident hi", int'(drv_hi_en), 0);
        chk("R5 coincident lo", int'(drv_lo_en), 0);
        step();
        chk("R5 still floating", int'(drv_hi_en) + int'(drv_lo_en), 0);

        // R6 lock acquisition with 1-cycle pump-down pulses
        restart(24);
        follow(0, n);
        chk("R2 first edge N=24", n, 25);
        chk("R4 dn cleared by ref", int'(drv_lo_en), 0);
        chk("R5 no up on late ref", int'(drv_hi_en), 0);
        chk("R6 unlocked after 1 ref", int'(unlock), 1);
        follow(0, n);
        chk("R1 period 24", n + 1, 24);
        follow(0, n);
        chk("R6 unlocked after 3 refs", int'(unlock), 1);
        follow(0, n);
        chk("R6 locked after 4 refs", int'(unlock), 0);

        // R3 mid-cycle load
        div_word = 14'd40; div_load = 1'b1;
        step();
        div_load = 1'b0;
        follow(0, n);
        chk("R3 current cycle kept", n + 2, 24);
        follow(0, n);
        chk("R3 new divisor next cycle", n + 1, 40);
        chk("R6 still locked", int'(unlock), 0);

        // R7 a 2-cycle pulse drops lock
        wait_lo(n);
        chk("R3 period 40", n + 1, 40);
        step();
        chk("R7 dn still high", int'(drv_lo_en), 1);
        chk("R7 lock held at 1 cycle", int'(unlock), 0);
        ref_tick = 1'b1;
        step();
        ref_tick = 1'b0;
        chk("R7 lock dropped", int'(unlock), 1);
        chk("R4 dn cleared", int'(drv_lo_en), 0);

        // R6 relock after 4 clean reference periods
        for (int k = 1; k <= 3; k++) begin
            follow(0, n);
            chk("R6 relock pending", int'(unlock), 1);
        end
        follow(0, n);
        chk("R6 relocked", int'(unlock), 0);

        // R8 power-down while locked
        pwr_down = 1'b1;
        step();
        chk("R8 unlock on pd", int'(unlock), 1);
        chk("R8 float on pd", int'(drv_hi_en) + int'(drv_lo_en), 0);
        pwr_down = 1'b0; vco_tick = 1'b0;
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule